// File: doc/BRIEF.md
# Sync-Triggered Burst Delay Buffer

This block records a burst of 8-bit samples into an on-chip circular store, beginning at the rising edge of a sync input, and plays the same burst back a programmable number of sample periods later. Samples arrive on a parallel bus together with a one-clock strobe. Playback uses the same strobe, so the replayed samples keep the spacing they had on capture. The 8-bit output code is meant to drive a resistor ladder or a DAC. It rests at mid-scale (0x80, zero volts on a bipolar ladder) whenever no burst is being played.

At each sync, the block latches three values for that burst: the current write position, the configured delay and the configured length. Capture of a new burst can therefore run while the previous burst is still being replayed. Only one replay can be waiting to start. A sync that arrives before the waiting replay has begun discards that replay.

Top module: `burst_echo_buffer`

## Requirements
- R1: After reset, and at any time no replay is active, `out_valid` is 0 and `out_code` is 0x80.
- R2: A capture starts only on a low-to-high transition of `sync_in`. A pulse that stays high across several strobes starts exactly one capture, and that capture counts the strobes during the pulse.
- R3: For a burst whose sync rises in the cycle of strobe k, or after strobe k and before strobe k+1, with latched delay D ≥ 1, captured sample i (taken at strobe k+i) is replayed at strobe k+D+i.
- R4: Exactly the latched length L of samples (1 ≤ L ≤ depth) is captured and replayed. After the last one, the output returns to idle at the next strobe.
- R5: The output changes only in the second clock cycle after a strobe cycle. It then holds, giving one replayed sample per strobe period in captured order.
- R6: A new burst may be captured while the previous one is replaying, and neither corrupts the other. A write and a read in the same cycle never address the same entry.
- R7: If a new sync arrives at or before strobe k+D of a waiting burst (that is, before that burst's first replay strobe), that burst is never played. Only the newer burst is queued.
- R8: Delay and length are sampled at the sync. Changing `cfg_delay` or `cfg_len` afterwards does not affect the burst in flight.
- R9: A strobe in the same cycle as a sync edge is not captured into the new burst. It still serves a replay that is already running or starting on that strobe.
- R10: The write position wraps modulo the depth and carries on across bursts, so bursts that straddle the end of the store replay correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Burst sync level; rising edge starts capture |
| smp_stb | input | 1 | One-cycle sample strobe |
| smp_data | input | 8 | Sample from the converter |
| cfg_delay | input | DLY_W | Replay delay in sample periods, latched at sync |
| cfg_len | input | ADDR_W+1 | Capture length in samples, latched at sync |
| out_code | output | 8 | Code to the ladder or DAC |
| out_valid | output | 1 | High while a replayed sample is presented |

## Verification
Two things can fall in the same cycle: the capture write of one burst and the replay read of an earlier one. A sync edge can also coincide with a strobe that starts, or continues, the previous burst's replay. The bench provokes both cases by spacing syncs closer than delay plus length, and by placing sync edges on strobe cycles, including the strobe that launches a waiting replay. Every strobe period is judged against an arithmetic model. For each period the model picks the most recent burst whose replay has started and was not displaced, then computes the sample value from the strobe index.

// File: rtl/beb_pkg.sv
package beb_pkg;

    localparam int SMP_W      = 8;
    localparam int DEF_ADDR_W = 11;
    localparam int DEF_DLY_W  = 12;

    typedef logic [SMP_W-1:0] smp_t;

    localparam smp_t MID_CODE = smp_t'(1) << (SMP_W - 1);

    typedef struct packed {
        logic valid;
        smp_t code;
    } out_slot_t;

    function automatic out_slot_t idle_slot();
        out_slot_t s;
        s.valid = 1'b0;
        s.code  = MID_CODE;
        return s;
    endfunction

    function automatic out_slot_t live_slot(smp_t c);
        out_slot_t s;
        s.valid = 1'b1;
        s.code  = c;
        return s;
    endfunction

endpackage

// File: rtl/beb_sync_edge.sv
module beb_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/beb_ram.sv
module beb_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/beb_capture.sv
module beb_capture #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stb,
    input  logic [ADDR_W:0]   len_cfg,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] base_addr,
    output logic              active
);
    localparam int LEN_W = ADDR_W + 1;

    logic [ADDR_W-1:0] wptr;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt_nxt;

    assign cnt_nxt   = cnt + LEN_W'(1);
    assign wr_en     = stb & active & ~start;
    assign wr_addr   = wptr;
    assign base_addr = wptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr   <= '0;
            cnt    <= '0;
            len_q  <= '0;
            active <= 1'b0;
        end else if (start) begin
            active <= (len_cfg != '0);
            cnt    <= '0;
            len_q  <= len_cfg;
        end else if (wr_en) begin
            wptr <= wptr + 1'b1;
            cnt  <= cnt_nxt;
            if (cnt_nxt == len_q) active <= 1'b0;
        end
    end
endmodule

// File: rtl/beb_replay.sv
module beb_replay #(
    parameter int ADDR_W = 11,
    parameter int DLY_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stb,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DLY_W-1:0]  delay_cfg,
    input  logic [ADDR_W:0]   len_cfg,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int LEN_W = ADDR_W + 1;

    logic              pend;
    logic [ADDR_W-1:0] pend_base;
    logic [LEN_W-1:0]  pend_len;
    logic [DLY_W-1:0]  dly;

    logic              act;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  left;

    logic fire_start;

    assign fire_start = stb & pend & (dly == '0) & (pend_len != '0);
    assign rd_en      = fire_start | (stb & act);
    assign rd_addr    = fire_start ? pend_base : addr;

    // waiting burst: a new sync always overwrites it
    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            pend_base <= '0;
            pend_len  <= '0;
            dly       <= '0;
        end else if (start) begin
            pend      <= 1'b1;
            pend_base <= base_addr;
            pend_len  <= len_cfg;
            dly       <= delay_cfg;
        end else if (stb && pend) begin
            if (dly == '0) pend <= 1'b0;
            else           dly  <= dly - 1'b1;
        end
    end

    // running burst: a launch takes over from any replay still running
    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= 1'b0;
            addr <= '0;
            left <= '0;
        end else if (fire_start) begin
            addr <= pend_base + 1'b1;
            left <= pend_len - LEN_W'(1);
            act  <= (pend_len > LEN_W'(1));
        end else if (stb && act) begin
            addr <= addr + 1'b1;
            left <= left - LEN_W'(1);
            act  <= (left > LEN_W'(1));
        end
    end
endmodule

// File: rtl/burst_echo_buffer.sv
module burst_echo_buffer
    import beb_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DLY_W  = DEF_DLY_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_in,
    input  logic              smp_stb,
    input  logic [7:0]        smp_data,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic [ADDR_W:0]   cfg_len,
    output logic [7:0]        out_code,
    output logic              out_valid
);
    logic              sync_rise;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] base_addr;
    logic              cap_active;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    smp_t              rd_data;

    logic      slot_v;
    logic      stb_q;
    out_slot_t out_q;

    beb_sync_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sync_in),
        .rise (sync_rise)
    );

    beb_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .start     (sync_rise),
        .stb       (smp_stb),
        .len_cfg   (cfg_len),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .base_addr (base_addr),
        .active    (cap_active)
    );

    beb_replay #(.ADDR_W(ADDR_W), .DLY_W(DLY_W)) u_play (
        .clk       (clk),
        .rst       (rst),
        .start     (sync_rise),
        .stb       (smp_stb),
        .base_addr (base_addr),
        .delay_cfg (cfg_delay),
        .len_cfg   (cfg_len),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr)
    );

    beb_ram #(.AW(ADDR_W), .DW(SMP_W)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (smp_data),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // the read returns one cycle after the strobe; the output register
    // loads it in that cycle, so every sample sees the same latency
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_v <= 1'b0;
            stb_q  <= 1'b0;
            out_q  <= idle_slot();
        end else begin
            stb_q <= smp_stb;
            if (smp_stb) slot_v <= rd_en;
            if (stb_q)   out_q  <= slot_v ? live_slot(rd_data) : idle_slot();
        end
    end

    assign out_code  = out_q.code;
    assign out_valid = out_q.valid;
endmodule

// File: rtl/burst_echo_buffer_chk.sv
module burst_echo_buffer_chk
    import beb_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              sync_in,
    input logic              smp_stb,
    input logic [ADDR_W:0]   cfg_len,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              cap_active,
    input logic [7:0]        out_code,
    input logic              out_valid
);
    p_idle_mid_r1: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> out_code == MID_CODE);

    p_cap_start_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(sync_in) && cfg_len != '0) |=> cap_active);

    p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(smp_stb, 2) |-> ($stable(out_code) && $stable(out_valid)));

    p_no_collide_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |-> wr_addr != rd_addr);
endmodule

bind burst_echo_buffer burst_echo_buffer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sync_in    (sync_in),
    .smp_stb    (smp_stb),
    .cfg_len    (cfg_len),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr),
    .cap_active (cap_active),
    .out_code   (out_code),
    .out_valid  (out_valid)
);

// File: tb/burst_echo_buffer_test.sv
module burst_echo_buffer_test;
    localparam int AW = 5;
    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync_in = 1'b0;
    logic          smp_stb = 1'b0;
    logic [7:0]    smp_data = '0;
    logic [DW-1:0] cfg_delay = '0;
    logic [AW:0]   cfg_len = '0;
    logic [7:0]    out_code;
    logic          out_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int g = 0;
    int sync_left = 0;
    int nb = 0;
    int b_s [64];
    int b_d [64];
    int b_l [64];
    string cur_tag = "R1";

    always #2 clk = ~clk;

    burst_echo_buffer #(.ADDR_W(AW), .DLY_W(DW)) uut (
        .clk       (clk),
        .rst       (rst),
        .sync_in   (sync_in),
        .smp_stb   (smp_stb),
        .smp_data  (smp_data),
        .cfg_delay (cfg_delay),
        .cfg_len   (cfg_len),
        .out_code  (out_code),
        .out_valid (out_valid)
    );

    function automatic logic [7:0] data_of(int idx);
        return 8'((idx * 29 + 7) % 256);
    endfunction

    // newest burst whose replay has begun and was not displaced decides
    task automatic expect_at(input int gi, output logic ev, output logic [7:0] ec);
        ev = 1'b0;
        ec = 8'h80;
        for (int b = nb - 1; b >= 0; b--) begin
            if (b + 1 < nb && b_s[b+1] <= b_s[b] + b_d[b]) continue;
            if (b_s[b] + b_d[b] + 1 <= gi) begin
                int i;
                i = gi - b_s[b] - b_d[b];
                if (i <= b_l[b]) begin
                    ev = 1'b1;
                    ec = data_of(b_s[b] + i);
                end
                return;
            end
        end
    endtask

    task automatic check(input string tag, input logic ev, input logic [7:0] ec);
        n_cmp++;
        if (out_valid !== ev || out_code !== ec) begin
            n_bad++;
            $display("FAIL %s strobe %0d: got valid=%0b code=%02h, expected valid=%0b code=%02h",
                     tag, g, out_valid, out_code, ev, ec);
        end
    endtask

    task automatic run_period(input bit do_sync, input int phase, input int width);
        for (int ph = 0; ph < 10; ph++) begin
            @(negedge clk);
            smp_stb = (ph == 0);
            if (ph == 0) begin
                g++;
                smp_data = data_of(g);
            end
            if (do_sync && ph == phase) sync_left = width;
            sync_in = (sync_left > 0);
            if (sync_left > 0) sync_left--;
            if (ph == 5) begin
                logic       ev;
                logic [7:0] ec;
                expect_at(g, ev, ec);
                check(cur_tag, ev, ec);
            end
        end
    endtask

    // gap = strobe periods from the previous sync period to this one
    task automatic burst(input int gap, input int d, input int l,
                         input int phase, input int width, input string tag);
        repeat (gap - 1) run_period(1'b0, 0, 0);
        cfg_delay = DW'(d);
        cfg_len   = (AW + 1)'(l);
        b_s[nb] = g + 1;
        b_d[nb] = d;
        b_l[nb] = l;
        nb++;
        cur_tag = tag;
        run_period(1'b1, phase, width);
        // R8: scribble the configuration while the burst is in flight
        cfg_delay = DW'(d * 3 + 1);
        cfg_len   = (AW + 1)'(l % 5 + 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R1: watchdog expired, got no end of run, expected end of run");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 1'b0, 8'h80);                   // reset state
        run_period(1'b0, 0, 0);
        run_period(1'b0, 0, 0);

        burst(3, 4, 3, 3, 9, "R2");                // long pulse spans a strobe
        burst(6, 1, 1, 0, 4, "R9");                // minimal delay, edge on strobe
        burst(12, 9, 8, 3, 4, "R3");
        burst(12, 9, 8, 4, 4, "R6");               // capture overlaps replay
        burst(12, 12, 3, 1, 4, "R8");
        burst(6, 5, 4, 2, 4, "R7");                // displaces the waiting burst
        burst(10, 3, 5, 0, 4, "R4");
        burst(5, 2, 2, 2, 4, "R5");
        burst(3, 7, 6, 0, 4, "R9");                // edge on the launching strobe
        for (int k = 0; k < 10; k++)
            burst(10 + k % 3, k % 5 + 1, k % 7 + 1, k % 6, 4, "R10");
        repeat (20) run_period(1'b0, 0, 0);
        cur_tag = "R1";
        repeat (5) run_period(1'b0, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule